// File: doc/BRIEF.md
# SPI Command Engine Register File

This block is the memory-mapped control face of an SPI command engine. Software uses it to hold the engine in soft reset or release it. It also enables and acknowledges four interrupt causes and reads back the identifier of the last completed synchronisation marker. Three status words report the free room in the command and transmit-data queues and the fill level of the receive-data queue.

Four data addresses move words between software and those queues. A write to one address pushes a 16-bit command word. A write to another pushes a transmit byte. One read address takes the oldest receive byte and pops it. Another read address returns that byte and leaves it in the queue.

The queues are outside the block. They are reached through push and pop strobes, data buses and room/level inputs. The bus is a single-cycle read or write strobe with a byte address. A single level interrupt line tells software that an enabled cause is pending.

Top module: `spi_cmd_regfile`

## Requirements
- R1: After reset `engine_rst` is 1, `irq` is 0, and reads of the enable, pending, source and marker-ID registers return 0.
- R2: Offset 0x40 is a read/write register whose bit 0 drives `engine_rst`. Writing 1 holds the engine in reset and writing 0 releases it.
- R3: Offset 0x80 is the interrupt enable, bits [3:0], read/write. In every interrupt word, bit 0 is command queue almost empty, bit 1 is transmit queue almost empty, bit 2 is receive queue almost full and bit 3 is the sync event.
- R4: Offset 0x84 reads the pending bits. Offset 0x88 reads pending AND enable. `irq` is 1 exactly when that AND is nonzero.
- R5: Writing 1 to a pending bit at 0x84 clears it. A cause that is active in the same cycle wins, so a bit whose condition still holds stays set. A bit whose condition has gone stays set until it is cleared.
- R6: Pending bit 0 is set in every cycle where `cmd_room` >= CMD_AE_TH. Bit 1 is set where `sdo_room` >= SDO_AE_TH. Bit 2 is set where `sdi_level` >= SDI_AF_TH.
- R7: A cycle with `sync_valid` high sets pending bit 3 and loads `sync_id_in` into the 8-bit marker-ID register at 0xC0.
- R8: Offsets 0xD0, 0xD4 and 0xD8 read `cmd_room`, `sdo_room` and `sdi_level`, zero-extended to 32 bits.
- R9: A write to 0xE0 pulses `cmd_push` in the same cycle with `cmd_data` = wdata[15:0]. A write to 0xE4 pulses `sdo_push` with `sdo_data` = wdata[7:0]. Either write is dropped when the matching room is 0.
- R10: A read of 0xE8 with `sdi_level` nonzero pulses `sdi_pop` in the same cycle and returns `sdi_head`. With `sdi_level` 0 it returns 0 and does not pop.
- R11: A read of 0xEC returns `sdi_head`, or 0 when `sdi_level` is 0, and never pops.
- R12: `rdata` is registered. It carries the value addressed in the cycle after `rd_en`, and is 0 in a cycle after no read or after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| engine_rst | output | 1 | Soft reset to the engine |
| irq | output | 1 | Level interrupt |
| cmd_push | output | 1 | Command queue push strobe |
| cmd_data | output | 16 | Command word pushed |
| cmd_room | input | CROOM_W | Free entries in the command queue |
| sdo_push | output | 1 | Transmit queue push strobe |
| sdo_data | output | 8 | Transmit byte pushed |
| sdo_room | input | DROOM_W | Free entries in the transmit queue |
| sdi_pop | output | 1 | Receive queue pop strobe |
| sdi_head | input | 8 | Oldest receive byte |
| sdi_level | input | RLVL_W | Bytes held in the receive queue |
| sync_valid | input | 1 | Sync marker completed this cycle |
| sync_id_in | input | 8 | Identifier of that marker |

## Verification
Push and pop strobes depend only on the current strobe, address and room or level, so they are due in the same cycle. The bench counts them at that rising edge. Register state, the pending bits and `irq` change one edge after the write, sync pulse or queue condition that causes them. Read data arrives one edge after `rd_en`. Every input is driven on a falling edge, and every value is sampled on the next falling edge, after exactly one rising edge.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam logic [7:0] A_HOLD  = 8'h40;
  localparam logic [7:0] A_IEN   = 8'h80;
  localparam logic [7:0] A_IPEND = 8'h84;
  localparam logic [7:0] A_ISRC  = 8'h88;
  localparam logic [7:0] A_SYNC  = 8'hC0;
  localparam logic [7:0] A_CROOM = 8'hD0;
  localparam logic [7:0] A_DROOM = 8'hD4;
  localparam logic [7:0] A_RLVL  = 8'hD8;
  localparam logic [7:0] A_CPUSH = 8'hE0;
  localparam logic [7:0] A_DPUSH = 8'hE4;
  localparam logic [7:0] A_RPOP  = 8'hE8;
  localparam logic [7:0] A_RPEEK = 8'hEC;

  localparam int NCAUSE = 4;

  // Queue threshold causes: [0] cmd almost empty, [1] sdo almost empty, [2] sdi almost full
  function automatic logic [2:0] queue_causes(input int unsigned croom, input int unsigned droom,
                                              input int unsigned rlvl, input int unsigned c_th,
                                              input int unsigned d_th, input int unsigned r_th);
    queue_causes = {rlvl >= r_th, droom >= d_th, croom >= c_th};
  endfunction
endpackage

// File: rtl/spi_rf_irq.sv
module spi_rf_irq
  import spi_rf_pkg::*;
#(
  parameter int unsigned CROOM_W   = 8,
  parameter int unsigned DROOM_W   = 8,
  parameter int unsigned RLVL_W    = 8,
  parameter int unsigned CMD_AE_TH = 12,
  parameter int unsigned SDO_AE_TH = 12,
  parameter int unsigned SDI_AF_TH = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CROOM_W-1:0] cmd_room,
  input  logic [DROOM_W-1:0] sdo_room,
  input  logic [RLVL_W-1:0]  sdi_level,
  input  logic               sync_valid,
  input  logic [7:0]         sync_id_in,
  input  logic               en_we,
  input  logic               clr_we,
  input  logic [NCAUSE-1:0]  wbits,
  output logic [NCAUSE-1:0]  int_en,
  output logic [NCAUSE-1:0]  pend,
  output logic [NCAUSE-1:0]  src,
  output logic [7:0]         sync_id,
  output logic               irq
);
  logic [2:0]        q_cause;
  logic [NCAUSE-1:0] cause_set;
  logic [NCAUSE-1:0] cause_clr;

  assign q_cause   = queue_causes(32'(cmd_room), 32'(sdo_room), 32'(sdi_level),
                                  CMD_AE_TH, SDO_AE_TH, SDI_AF_TH);
  assign cause_set = {sync_valid, q_cause};
  assign cause_clr = clr_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      int_en  <= '0;
      sync_id <= '0;
    end else begin
      pend <= (pend & ~cause_clr) | cause_set;
      if (en_we)      int_en  <= wbits;
      if (sync_valid) sync_id <= sync_id_in;
    end
  end

  assign src = pend & int_en;
  assign irq = |src;
endmodule

// File: rtl/spi_rf_fifo_gate.sv
module spi_rf_fifo_gate #(
  parameter int unsigned CROOM_W = 8,
  parameter int unsigned DROOM_W = 8,
  parameter int unsigned RLVL_W  = 8
) (
  input  logic               cmd_wr,
  input  logic               sdo_wr,
  input  logic               sdi_rd,
  input  logic [15:0]        wdata,
  input  logic [CROOM_W-1:0] cmd_room,
  input  logic [DROOM_W-1:0] sdo_room,
  input  logic [RLVL_W-1:0]  sdi_level,
  output logic               cmd_push,
  output logic [15:0]        cmd_data,
  output logic               sdo_push,
  output logic [7:0]         sdo_data,
  output logic               sdi_pop,
  output logic               sdi_empty
);
  assign sdi_empty = (sdi_level == '0);
  assign cmd_push  = cmd_wr && (cmd_room != '0);
  assign sdo_push  = sdo_wr && (sdo_room != '0);
  assign sdi_pop   = sdi_rd && !sdi_empty;
  assign cmd_data  = wdata;
  assign sdo_data  = wdata[7:0];
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile
  import spi_rf_pkg::*;
#(
  parameter int unsigned CROOM_W   = 8,
  parameter int unsigned DROOM_W   = 8,
  parameter int unsigned RLVL_W    = 8,
  parameter int unsigned CMD_AE_TH = 12,
  parameter int unsigned SDO_AE_TH = 12,
  parameter int unsigned SDI_AF_TH = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [15:0]        wdata,
  output logic [31:0]        rdata,
  output logic               engine_rst,
  output logic               irq,
  output logic               cmd_push,
  output logic [15:0]        cmd_data,
  input  logic [CROOM_W-1:0] cmd_room,
  output logic               sdo_push,
  output logic [7:0]         sdo_data,
  input  logic [DROOM_W-1:0] sdo_room,
  output logic               sdi_pop,
  input  logic [7:0]         sdi_head,
  input  logic [RLVL_W-1:0]  sdi_level,
  input  logic               sync_valid,
  input  logic [7:0]         sync_id_in
);
  localparam int PADW = 32 - NCAUSE;

  logic              hold_we, en_we, clr_we, cmd_wr, sdo_wr, sdi_rd;
  logic [NCAUSE-1:0] int_en_w, pend_w, src_w;
  logic [7:0]        sync_id_w;
  logic              sdi_empty_w;
  logic [31:0]       rd_mux;

  assign hold_we = wr_en && (addr == A_HOLD);
  assign en_we   = wr_en && (addr == A_IEN);
  assign clr_we  = wr_en && (addr == A_IPEND);
  assign cmd_wr  = wr_en && (addr == A_CPUSH);
  assign sdo_wr  = wr_en && (addr == A_DPUSH);
  assign sdi_rd  = rd_en && (addr == A_RPOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       engine_rst <= 1'b1;
    else if (hold_we) engine_rst <= wdata[0];
  end

  spi_rf_irq #(
    .CROOM_W(CROOM_W), .DROOM_W(DROOM_W), .RLVL_W(RLVL_W),
    .CMD_AE_TH(CMD_AE_TH), .SDO_AE_TH(SDO_AE_TH), .SDI_AF_TH(SDI_AF_TH)
  ) u_irq (
    .clk(clk), .rst_n(rst_n),
    .cmd_room(cmd_room), .sdo_room(sdo_room), .sdi_level(sdi_level),
    .sync_valid(sync_valid), .sync_id_in(sync_id_in),
    .en_we(en_we), .clr_we(clr_we), .wbits(wdata[NCAUSE-1:0]),
    .int_en(int_en_w), .pend(pend_w), .src(src_w), .sync_id(sync_id_w), .irq(irq)
  );

  spi_rf_fifo_gate #(
    .CROOM_W(CROOM_W), .DROOM_W(DROOM_W), .RLVL_W(RLVL_W)
  ) u_gate (
    .cmd_wr(cmd_wr), .sdo_wr(sdo_wr), .sdi_rd(sdi_rd), .wdata(wdata),
    .cmd_room(cmd_room), .sdo_room(sdo_room), .sdi_level(sdi_level),
    .cmd_push(cmd_push), .cmd_data(cmd_data),
    .sdo_push(sdo_push), .sdo_data(sdo_data),
    .sdi_pop(sdi_pop), .sdi_empty(sdi_empty_w)
  );

  always_comb begin
    case (addr)
      A_HOLD:  rd_mux = {31'd0, engine_rst};
      A_IEN:   rd_mux = {{PADW{1'b0}}, int_en_w};
      A_IPEND: rd_mux = {{PADW{1'b0}}, pend_w};
      A_ISRC:  rd_mux = {{PADW{1'b0}}, src_w};
      A_SYNC:  rd_mux = {24'd0, sync_id_w};
      A_CROOM: rd_mux = 32'(cmd_room);
      A_DROOM: rd_mux = 32'(sdo_room);
      A_RLVL:  rd_mux = 32'(sdi_level);
      A_RPOP, A_RPEEK: rd_mux = sdi_empty_w ? 32'd0 : {24'd0, sdi_head};
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : 32'd0;
  end
endmodule

// File: rtl/spi_cmd_regfile_chk.sv
module spi_cmd_regfile_chk
  import spi_rf_pkg::*;
#(
  parameter int unsigned CROOM_W   = 8,
  parameter int unsigned DROOM_W   = 8,
  parameter int unsigned RLVL_W    = 8,
  parameter int unsigned CMD_AE_TH = 12,
  parameter int unsigned SDO_AE_TH = 12,
  parameter int unsigned SDI_AF_TH = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [15:0]        wdata,
  input logic               engine_rst,
  input logic               irq,
  input logic               cmd_push,
  input logic [CROOM_W-1:0] cmd_room,
  input logic               sdo_push,
  input logic [DROOM_W-1:0] sdo_room,
  input logic               sdi_pop,
  input logic [RLVL_W-1:0]  sdi_level,
  input logic               sync_valid,
  input logic [7:0]         sync_id_in,
  input logic [NCAUSE-1:0]  pend,
  input logic [NCAUSE-1:0]  int_en,
  input logic [7:0]         sync_id
);
  a_r2_hold_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_HOLD) |=> engine_rst == $past(wdata[0]));

  a_r4_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);

  a_r6_cmd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cmd_room) >= CMD_AE_TH) |=> pend[0]);

  a_r6_sdo_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sdo_room) >= SDO_AE_TH) |=> pend[1]);

  a_r6_sdi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sdi_level) >= SDI_AF_TH) |=> pend[2]);

  a_r7_sync_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> pend[3]);

  a_r7_sync_id_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> sync_id == $past(sync_id_in));

  a_r9_no_cmd_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> cmd_room != '0);

  a_r9_no_sdo_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_push |-> sdo_room != '0);

  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    sdi_pop |-> sdi_level != '0);
endmodule

bind spi_cmd_regfile spi_cmd_regfile_chk #(
  .CROOM_W(CROOM_W), .DROOM_W(DROOM_W), .RLVL_W(RLVL_W),
  .CMD_AE_TH(CMD_AE_TH), .SDO_AE_TH(SDO_AE_TH), .SDI_AF_TH(SDI_AF_TH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .engine_rst(engine_rst), .irq(irq),
  .cmd_push(cmd_push), .cmd_room(cmd_room),
  .sdo_push(sdo_push), .sdo_room(sdo_room),
  .sdi_pop(sdi_pop), .sdi_level(sdi_level),
  .sync_valid(sync_valid), .sync_id_in(sync_id_in),
  .pend(pend_w), .int_en(int_en_w), .sync_id(sync_id_w)
);

// File: tb/spi_cmd_regfile_tb.sv
`timescale 1ns/1ps
module spi_cmd_regfile_tb;
  localparam int unsigned CTH = 12;
  localparam int unsigned DTH = 10;
  localparam int unsigned LTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        engine_rst, irq;
  logic        cmd_push, sdo_push, sdi_pop;
  logic [15:0] cmd_data;
  logic [7:0]  sdo_data;
  logic [7:0]  cmd_room = '0, sdo_room = '0, sdi_level = '0, sdi_head = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id_in = '0;

  int checks = 0, errors = 0;
  int cmd_pushes = 0, sdo_pushes = 0, pops = 0;
  logic [15:0] last_cmd = '0;
  logic [7:0]  last_sdo = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_regfile #(
    .CROOM_W(8), .DROOM_W(8), .RLVL_W(8),
    .CMD_AE_TH(CTH), .SDO_AE_TH(DTH), .SDI_AF_TH(LTH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .engine_rst(engine_rst), .irq(irq),
    .cmd_push(cmd_push), .cmd_data(cmd_data), .cmd_room(cmd_room),
    .sdo_push(sdo_push), .sdo_data(sdo_data), .sdo_room(sdo_room),
    .sdi_pop(sdi_pop), .sdi_head(sdi_head), .sdi_level(sdi_level),
    .sync_valid(sync_valid), .sync_id_in(sync_id_in)
  );

  always @(posedge clk) begin
    if (cmd_push) begin cmd_pushes++; last_cmd = cmd_data; end
    if (sdo_push) begin sdo_pushes++; last_sdo = sdo_data; end
    if (sdi_pop)  pops++;
  end

  function automatic logic [3:0] want_causes(input logic [7:0] c, input logic [7:0] d,
                                             input logic [7:0] l);
    logic [3:0] r;
    r = 4'b0000;
    if (int'(c) >= int'(CTH)) r[0] = 1'b1;
    if (int'(d) >= int'(DTH)) r[1] = 1'b1;
    if (int'(l) >= int'(LTH)) r[2] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic set_q(input logic [7:0] c, input logic [7:0] d, input logic [7:0] l);
    @(negedge clk); cmd_room = c; sdo_room = d; sdi_level = l;
    @(negedge clk);
  endtask

  task automatic sync_pulse(input logic [7:0] id);
    @(negedge clk); sync_valid = 1'b1; sync_id_in = id;
    @(negedge clk); sync_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 engine_rst", {31'd0, engine_rst}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_rd(8'h80, v); chk("R1 enable", v, 32'd0);
    bus_rd(8'h84, v); chk("R1 pending", v, 32'd0);
    bus_rd(8'h88, v); chk("R1 source", v, 32'd0);
    bus_rd(8'hC0, v); chk("R1 sync id", v, 32'd0);

    // R2 soft reset register
    bus_rd(8'h40, v); chk("R2 hold readback", v, 32'd1);
    bus_wr(8'h40, 16'h0000); chk("R2 release", {31'd0, engine_rst}, 32'd0);
    bus_rd(8'h40, v); chk("R2 readback 0", v, 32'd0);
    bus_wr(8'h40, 16'h0001); chk("R2 hold", {31'd0, engine_rst}, 32'd1);
    bus_wr(8'h40, 16'h0000);

    // R3 enable register
    bus_wr(8'h80, 16'h000A); bus_rd(8'h80, v); chk("R3 enable rw", v, 32'h0000000A);
    bus_wr(8'h80, 16'h0000);

    // R7 sync event
    sync_pulse(8'hA5);
    bus_rd(8'hC0, v); chk("R7 sync id", v, 32'h000000A5);
    bus_rd(8'h84, v); chk("R7 sync pending", v, 32'h00000008);
    chk("R4 masked irq", {31'd0, irq}, 32'd0);
    bus_wr(8'h84, 16'h0008); bus_rd(8'h84, v); chk("R5 w1c sync", v, 32'd0);

    // R4 enable + source + irq
    bus_wr(8'h80, 16'h0008);
    sync_pulse(8'h3C);
    chk("R4 irq on sync", {31'd0, irq}, 32'd1);
    bus_rd(8'h88, v); chk("R4 source", v, 32'h00000008);
    bus_wr(8'h84, 16'h0008);
    chk("R4 irq cleared", {31'd0, irq}, 32'd0);
    bus_wr(8'h80, 16'h0000);

    // R10 pop when empty / nonempty, R11 peek
    sdi_head = 8'h5C;
    p0 = pops;
    bus_rd(8'hE8, v); chk("R10 empty pop data", v, 32'd0);
    chk("R10 empty no pop", 32'(pops - p0), 32'd0);
    set_q(8'd0, 8'd0, 8'd3);
    bus_rd(8'hE8, v); chk("R10 pop data", v, 32'h0000005C);
    chk("R10 pop strobe", 32'(pops - p0), 32'd1);
    bus_rd(8'hEC, v); chk("R11 peek data", v, 32'h0000005C);
    chk("R11 peek no pop", 32'(pops - p0), 32'd1);
    set_q(8'd0, 8'd0, 8'd0);
    bus_rd(8'hEC, v); chk("R11 peek empty", v, 32'd0);

    // R9 pushes with and without room
    p0 = cmd_pushes;
    bus_wr(8'hE0, 16'h1234); chk("R9 cmd full dropped", 32'(cmd_pushes - p0), 32'd0);
    set_q(8'd5, 8'd0, 8'd0);
    bus_wr(8'hE0, 16'h1234);
    chk("R9 cmd push", 32'(cmd_pushes - p0), 32'd1);
    chk("R9 cmd data", {16'd0, last_cmd}, 32'h00001234);
    p0 = sdo_pushes;
    bus_wr(8'hE4, 16'hBEEF); chk("R9 sdo full dropped", 32'(sdo_pushes - p0), 32'd0);
    set_q(8'd5, 8'd1, 8'd0);
    bus_wr(8'hE4, 16'hBEEF);
    chk("R9 sdo push", 32'(sdo_pushes - p0), 32'd1);
    chk("R9 sdo data", {24'd0, last_sdo}, 32'h000000EF);

    // R6 threshold boundaries
    set_q(8'(CTH - 1), 8'(DTH - 1), 8'(LTH - 1));
    bus_wr(8'h84, 16'h000F); bus_rd(8'h84, v); chk("R6 below thresholds", v, 32'd0);
    set_q(8'(CTH), 8'(DTH), 8'(LTH));
    bus_rd(8'h84, v); chk("R6 at thresholds", v, 32'h00000007);

    // R5 set wins over clear; sticky after condition drops
    bus_wr(8'h84, 16'h0001); bus_rd(8'h84, v); chk("R5 clear loses to active cause", v, 32'h00000007);
    set_q(8'd0, 8'd0, 8'd0);
    bus_rd(8'h84, v); chk("R5 sticky after cause gone", v, 32'h00000007);
    bus_wr(8'h84, 16'h0005); bus_rd(8'h84, v); chk("R5 partial clear", v, 32'h00000002);
    bus_wr(8'h84, 16'h0002); bus_rd(8'h84, v); chk("R5 full clear", v, 32'd0);

    // R12 rdata returns to zero; unmapped read
    bus_rd(8'hD0, v);
    @(negedge clk); chk("R12 idle rdata", rdata, 32'd0);
    bus_rd(8'h44, v); chk("R12 unmapped", v, 32'd0);

    // Random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] c, d, l, hd;
      logic [3:0] en, want;
      logic [15:0] cw;
      int pc;
      c = 8'($urandom % 24); d = 8'($urandom % 24); l = 8'($urandom % 16);
      hd = 8'($urandom); en = 4'($urandom); cw = 16'($urandom);
      sdi_head = hd;
      set_q(c, d, l);
      want = want_causes(c, d, l);
      bus_wr(8'h80, {12'd0, en});
      bus_wr(8'h84, 16'h000F);
      bus_rd(8'h84, v); chk("R6 random pending", v, {28'd0, want});
      bus_rd(8'h88, v); chk("R4 random source", v, {28'd0, want & en});
      chk("R4 random irq", {31'd0, irq}, {31'd0, |(want & en)});
      bus_rd(8'hD0, v); chk("R8 cmd room", v, {24'd0, c});
      bus_rd(8'hD4, v); chk("R8 sdo room", v, {24'd0, d});
      bus_rd(8'hD8, v); chk("R8 sdi level", v, {24'd0, l});
      pc = cmd_pushes;
      bus_wr(8'hE0, cw);
      chk("R9 random push", 32'(cmd_pushes - pc), (c != 0) ? 32'd1 : 32'd0);
      pc = pops;
      bus_rd(8'hE8, v);
      chk("R10 random pop data", v, (l != 0) ? {24'd0, hd} : 32'd0);
      chk("R10 random pop count", 32'(pops - pc), (l != 0) ? 32'd1 : 32'd0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule